// File: doc/BRIEF.md
# Four-Channel Round-Robin Transfer Arbiter

This block decides which of four transfer channels may use a shared data mover. Each channel raises a level request and holds it until it is granted. The arbiter issues a one-hot grant to one channel and keeps it for the whole transfer. It never preempts: requests that arrive during a transfer wait. The granted channel ends its transfer by pulsing a done strobe for one cycle.

Channel priority follows a ring. The ring is stored as the index of the channel that currently ranks highest. The other channels rank below it in rising cyclic order. When a transfer completes, the ring turns so that the channel that just finished ranks last. Arbitration then restarts one cycle later, using the rotated order and the requests still pending.

The grant, a busy flag and the index of the highest-ranked channel are visible at the ports. The asynchronous active-low reset is released through a two-stage synchronizer. Internal state therefore leaves reset two rising clock edges after the reset input goes high.

Top module: `rr_xfer_arbiter`

## Requirements
- R1: After reset, the grant is 4'b0000, busy is low, and the top-priority index is 0, giving the order 0 > 1 > 2 > 3.
- R2: While idle, if one or more request bits are high at a rising edge, that edge grants exactly one of them. The winner is the requester first in the order top, top+1, top+2, top+3 (mod 4). The grant bit position equals the channel number.
- R3: Once issued, the grant stays unchanged, whatever the requests do, until a cycle in which done is high.
- R4: When done is high while channel k holds the grant, the next edge clears the grant and sets the top-priority index to (k+1) mod 4. As a result, k ranks lowest and the cyclic order of the others is kept.
- R5: The cycle after a completion is idle, and arbitration happens at the following edge using the rotated order. The channel that just completed therefore wins again only if it is the sole requester.
- R6: A done pulse while no grant is active leaves the top-priority index unchanged. It does not stop a request present in that same cycle from being granted.
- R7: With no grant active and no request high, the grant stays 4'b0000 and the top-priority index is unchanged.
- R8: Busy is high exactly in the cycles in which a grant bit is high.
- R9: Starting from order 0>1>2>3, suppose channels 0 and 3 request together and channel 1 requests during channel 0's transfer. The grants then run 0, 1, 3. The order passes through 1>2>3>0 and 2>3>0>1, and returns to 0>1>2>3 after channel 3 completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| req_i | input | 4 | Per-channel level request, bit n for channel n |
| done_i | input | 1 | One-cycle strobe from the granted channel ending its transfer |
| gnt_o | output | 4 | One-hot grant, bit n for channel n, all zero when idle |
| busy_o | output | 1 | High while a transfer is granted |
| top_o | output | 2 | Index of the channel currently ranked highest |

## Verification
Two functions can meet in one idle cycle: a stray done strobe, which must be ignored, and the arrival of a new request, which must be arbitrated. The bench drives both in the same cycle. It passes if the request is granted on the next edge and the priority index keeps its value. A second meeting happens at a completion edge: the ring rotates while other channels are already waiting. The bench holds several requests through the done cycle. It then checks that the grant one cycle later goes to the winner under the rotated order, not the order that applied before the completion.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } arb_state_e;

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rr_prio_pick.sv
module rr_prio_pick #(
  parameter int NCH   = 4,
  parameter int IDX_W = 2
) (
  input  logic [NCH-1:0]   req,
  input  logic [IDX_W-1:0] top,
  output logic [NCH-1:0]   pick_oh,
  output logic             pick_any
);

  always_comb begin
    pick_oh = '0;
    for (int ofs = 0; ofs < NCH; ofs++) begin
      int ch;
      ch = (int'(top) + ofs) % NCH;
      if ((pick_oh == '0) && req[ch]) begin
        pick_oh[ch] = 1'b1;
      end
    end
    pick_any = |pick_oh;
  end

endmodule

// File: rtl/rr_ring_next.sv
module rr_ring_next #(
  parameter int NCH   = 4,
  parameter int IDX_W = 2
) (
  input  logic [NCH-1:0]   owner_oh,
  output logic [IDX_W-1:0] next_top
);

  logic [IDX_W-1:0] owner_idx;

  always_comb begin
    owner_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (owner_oh[i]) begin
        owner_idx = owner_idx | IDX_W'(i);
      end
    end
  end

  assign next_top = (int'(owner_idx) == NCH - 1) ? '0 : owner_idx + 1'b1;

endmodule

// File: rtl/rr_xfer_arbiter.sv
module rr_xfer_arbiter
  import rr_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic             done_i,
  output logic [NCH-1:0]   gnt_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] top_o
);

  logic             rst_sync_n;
  arb_state_e       state_q, state_d;
  logic [NCH-1:0]   gnt_q, gnt_d;
  logic [IDX_W-1:0] top_q, top_d;
  logic             gnt_en, top_en, state_en;
  logic [NCH-1:0]   pick_oh;
  logic             pick_any;
  logic [IDX_W-1:0] ring_top;

  rr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rr_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .req      (req_i),
    .top      (top_q),
    .pick_oh  (pick_oh),
    .pick_any (pick_any)
  );

  rr_ring_next #(.NCH(NCH), .IDX_W(IDX_W)) u_ring (
    .owner_oh (gnt_q),
    .next_top (ring_top)
  );

  // Next-state process
  always_comb begin
    state_d  = state_q;
    gnt_d    = gnt_q;
    top_d    = top_q;
    gnt_en   = 1'b0;
    top_en   = 1'b0;
    state_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_any) begin
          gnt_d    = pick_oh;
          state_d  = ST_XFER;
          gnt_en   = 1'b1;
          state_en = 1'b1;
        end
      end
      ST_XFER: begin
        if (done_i) begin
          gnt_d    = '0;
          top_d    = ring_top;
          state_d  = ST_IDLE;
          gnt_en   = 1'b1;
          top_en   = 1'b1;
          state_en = 1'b1;
        end
      end
      default: begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      top_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (gnt_en)   gnt_q   <= gnt_d;
      if (top_en)   top_q   <= top_d;
    end
  end

  assign gnt_o  = gnt_q;
  assign busy_o = (state_q == ST_XFER);
  assign top_o  = top_q;

endmodule

// File: rtl/rr_xfer_arbiter_chk.sv
module rr_xfer_arbiter_chk #(
  parameter int NCH = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req_i,
  input logic             done_i,
  input logic [NCH-1:0]   gnt_o,
  input logic             busy_o,
  input logic [IDX_W-1:0] top_o
);

  logic [IDX_W-1:0] want_top;

  always_comb begin
    want_top = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt_o[i]) want_top = IDX_W'((i + 1) % NCH);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R2

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0 && (gnt_o & $past(req_i)) == gnt_o)); // R2

  AST_HOLD_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && !done_i) |=> $stable(gnt_o)); // R3

  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && done_i) |=> (gnt_o == '0)); // R4

  AST_RING_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && done_i) |=> (top_o == $past(want_top))); // R4

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && done_i) |=> !busy_o); // R5

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && done_i) |=> $stable(top_o)); // R6

  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0 && $stable(top_o))); // R7

  AST_BUSY_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (gnt_o != '0)); // R8

endmodule

bind rr_xfer_arbiter rr_xfer_arbiter_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .req_i  (req_i),
  .done_i (done_i),
  .gnt_o  (gnt_o),
  .busy_o (busy_o),
  .top_o  (top_o)
);

// File: tb/rr_xfer_arbiter_test.sv
`timescale 1ns/1ps
module rr_xfer_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       done;
  logic [3:0] gnt;
  logic       busy;
  logic [1:0] top;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  rr_xfer_arbiter #(.NCH(4)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req),
    .done_i (done),
    .gnt_o  (gnt),
    .busy_o (busy),
    .top_o  (top)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int g, input int b, input int t);
    chk({tag, " grant"}, int'(gnt), g);
    chk({tag, " busy R8"}, int'(busy), b);
    chk({tag, " top"}, int'(top), t);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '0; done = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk_out("R1 reset", 0, 0, 0);
  endtask

  task automatic t_no_request();
    repeat (3) step();
    chk_out("R7 quiet", 0, 0, 0);
  endtask

  task automatic t_idle_done();
    done = 1'b1; step(); done = 1'b0;
    chk_out("R6 stray done", 0, 0, 0);
    step();
    chk_out("R6 stray done after", 0, 0, 0);
  endtask

  task automatic t_sequence();
    req = 4'b1001; step();
    chk_out("R2 R9 first grant ch0", 1, 1, 0);
    req = 4'b1010; step();
    chk_out("R3 hold ch0 with ch1 waiting", 1, 1, 0);
    step();
    chk_out("R3 hold ch0 again", 1, 1, 0);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 R9 ch0 done order 1230", 0, 0, 1);
    step();
    chk_out("R5 R9 second grant ch1", 2, 1, 1);
    req = 4'b1000; step();
    chk_out("R3 hold ch1", 2, 1, 1);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 R9 ch1 done order 2301", 0, 0, 2);
    step();
    chk_out("R9 third grant ch3", 8, 1, 2);
    req = 4'b0000; done = 1'b1; step(); done = 1'b0;
    chk_out("R9 ch3 done order back to 0123", 0, 0, 0);
    step();
    chk_out("R7 idle after sequence", 0, 0, 0);
  endtask

  task automatic t_sole_rewin();
    req = 4'b0001; step();
    chk_out("R2 lone ch0", 1, 1, 0);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R5 idle gap after done", 0, 0, 1);
    step();
    chk_out("R5 sole requester wins again", 1, 1, 1);
    req = 4'b0000; done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ch0 done top1", 0, 0, 1);
  endtask

  task automatic t_finisher_loses();
    req = 4'b0011; step();
    chk_out("R2 ch1 wins at top1", 2, 1, 1);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ch1 done top2", 0, 0, 2);
    step();
    chk_out("R5 ch0 beats finisher ch1", 1, 1, 2);
    req = 4'b0010; done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ch0 done top1", 0, 0, 1);
    step();
    chk_out("R5 ch1 granted under top1", 2, 1, 1);
    req = 4'b0000; done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ch1 done top2", 0, 0, 2);
  endtask

  task automatic t_done_with_request();
    req = 4'b0001; done = 1'b1; step(); done = 1'b0;
    chk_out("R6 idle done with request granted", 1, 1, 2);
    req = 4'b0000; done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ch0 done top1", 0, 0, 1);
  endtask

  task automatic t_full_ring();
    req = 4'b1111; step();
    chk_out("R2 all request top1", 2, 1, 1);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ring to 2", 0, 0, 2);
    step();
    chk_out("R2 all request top2", 4, 1, 2);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ring to 3", 0, 0, 3);
    step();
    chk_out("R2 all request top3", 8, 1, 3);
    done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ring wraps to 0", 0, 0, 0);
    step();
    chk_out("R2 all request top0", 1, 1, 0);
    req = 4'b0000; done = 1'b1; step(); done = 1'b0;
    chk_out("R4 ring to 1", 0, 0, 1);
    repeat (2) step();
    chk_out("R7 final idle", 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_no_request();
    t_idle_done();
    t_sequence();
    t_sole_rewin();
    t_finisher_loses();
    t_done_with_request();
    t_full_ring();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule